// File: doc/BRIEF.md
# Single-Channel Memory Transfer Engine

This block is one channel of a direct-memory-access engine. Software programs four registers (a control word, a source address, a destination address and an item count), and the channel then copies that many items from the source to the destination, one item at a time. Each item is read through a single-beat read port and then written through a single-beat write port.

Each of the four registers can be written in two ways. A plain write only loads the register. A trigger write loads it and also starts the channel. Within the control word, software chooses:
- the item width;
- whether each address advances;
- an aligned wrap window on one side;
- byte-order reversal;
- a pacing request line;
- the channel to start next when this one completes;
- whether completion interrupts are suppressed until a trigger write of zero arrives.

Software can pause the channel by clearing its enable bit, or stop it with an abort. An abort drains any item that has already been read before the channel reports idle.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, `busy`, `irq`, `rdReq`, `wrReq` and `chainFire` are all 0.
- R2: `cfgWrAddr[1:0]` selects the register: 0 is the control word, 1 the source address, 2 the destination address, 3 the item count. A write with `cfgWrAddr[2]`=0 only loads the register. A write with `cfgWrAddr[2]`=1 loads it and starts an idle channel, provided the enable bit (control bit 0) is 1 after the write.
- R3: Control bits [2:1] set the item width: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits. The code also appears on `rdSize` and `wrSize`. Bit 3 enables source increment and bit 4 enables destination increment. An increment adds 1, 2 or 4 bytes per item; a side without increment keeps its address.
- R4: Control bits [8:5] hold a ring size n. With n>0 only the low n bits of the ringed address change, so it wraps on a 2^n-byte boundary. Bit 9 set puts the ring on the destination side; bit 9 clear puts it on the source side. n=0 means no wrap.
- R5: The count is in items. A started channel performs exactly that many read/write pairs and holds `busy` high until the count reaches zero. A start with a count of zero completes with no transfers.
- R6: With control bit 10 set, 16-bit items have their low two bytes exchanged and 32-bit items have all four bytes reversed. 8-bit items pass unchanged.
- R7: Normal completion sets `irq`, which stays set until an `irqClr` cycle clears it. If completion and `irqClr` fall in the same cycle, the set wins.
- R8: With control bit 11 (quiet) set, completion does not set `irq`. Instead, a trigger write of value zero to any register sets `irq` and does not start the channel.
- R9: Control bits [17:12] select pacing. Value 63 means always ready. A value below the number of request lines selects that `dreq` line. Any other value never paces. A read is issued only while the selected pacing is true.
- R10: Control bits [21:18] name the chain target. On normal completion `chainFire` pulses for one cycle with `chainTarget` equal to that value, unless the value equals the channel's own index (default 2). A `chainIn` pulse starts an idle, enabled channel.
- R11: While enable is 0, the channel issues no new reads, keeps `busy` high if a sequence is under way, and ignores trigger writes and `chainIn`.
- R12: An `abortReq` pulse ends the sequence. If a read is outstanding or done, the matching write still completes before `busy` falls. An aborted sequence sets neither `irq` nor `chainFire`.
- R13: At most one item is in flight. `rdReq` stays high until `rdValid`, the write follows, and `wrReq` stays high until `wrAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Register write strobe |
| cfgWrAddr | input | 3 | Register select [1:0], trigger alias [2] |
| cfgWrData | input | 32 | Register write value |
| irqClr | input | 1 | Clears the sticky interrupt |
| chainIn | input | 1 | Start pulse from another channel |
| abortReq | input | 1 | Abort pulse |
| dreq | input | NREQ | Pacing request lines |
| rdReq | output | 1 | Read request |
| rdAddr | output | 32 | Read address |
| rdSize | output | 2 | Read item width code |
| rdValid | input | 1 | Read data valid |
| rdData | input | 32 | Read data |
| wrReq | output | 1 | Write request |
| wrAddr | output | 32 | Write address |
| wrSize | output | 2 | Write item width code |
| wrData | output | 32 | Write data |
| wrAck | input | 1 | Write accepted |
| busy | output | 1 | Sequence under way |
| irq | output | 1 | Sticky completion interrupt |
| chainFire | output | 1 | One-cycle start pulse for the chain target |
| chainTarget | output | 4 | Index of the channel to start |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is the completion that sets the interrupt and a software clear of that interrupt. The bench holds `irqClr` high for the whole of a one-item sequence and expects `irq` to read 1 in the first idle cycle.

The second pair is an abort and a read that has been issued but not yet answered. The bench withholds `rdValid`, pulses `abortReq`, and then expects `busy` to stay high until the pending item is both read and written. It also expects that no interrupt or chain pulse follows the abort.

// File: rtl/dce_pkg.sv
package dce_pkg;

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int CFG_W = 22;
  localparam logic [5:0] REQ_ALWAYS = 6'h3F;

  // control word, bit 21 down to bit 0
  typedef struct packed {
    logic [3:0] chainTo;
    logic [5:0] reqSel;
    logic       quiet;
    logic       swap;
    logic       ringWr;
    logic [3:0] ringBits;
    logic       wrInc;
    logic       rdInc;
    logic [1:0] size;
    logic       enable;
  } cfg_t;

  typedef struct packed {
    logic takeData;
    logic advance;
  } strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_READ,
    ST_WRITE
  } state_t;

  function automatic logic [ADDR_W-1:0] stepAddr(
    input logic [ADDR_W-1:0] a,
    input logic [1:0]        size,
    input logic [3:0]        ringBits,
    input logic              ringOn
  );
    logic [ADDR_W-1:0] stepped;
    logic [ADDR_W-1:0] keepMask;
    stepped  = a + ((size == 2'd0) ? 32'd1 : (size == 2'd1) ? 32'd2 : 32'd4);
    keepMask = (ringOn && ringBits != 4'd0) ? ((32'd1 << ringBits) - 32'd1) : '1;
    return (a & ~keepMask) | (stepped & keepMask);
  endfunction

  function automatic logic [DATA_W-1:0] laneSwap(
    input logic [DATA_W-1:0] d,
    input logic [1:0]        size,
    input logic              en
  );
    if (!en) return d;
    case (size)
      2'd1:    return {d[31:16], d[7:0], d[15:8]};
      2'd2:    return {d[7:0], d[15:8], d[23:16], d[31:24]};
      default: return d;
    endcase
  endfunction

endpackage

// File: rtl/dce_datapath.sv
module dce_datapath
  import dce_pkg::*;
#(
  parameter int CH_IDX = 2,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [2:0]        cfgWrAddr,
  input  logic [31:0]       cfgWrData,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] rdData,
  output cfg_t              cfg,
  output logic              countZero,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData
);

  localparam logic [3:0] SELF = 4'(CH_IDX);
  localparam logic [CFG_W-1:0] CFG_RESET =
    {SELF, REQ_ALWAYS, 1'b0, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 2'd2, 1'b0};

  logic [CFG_W-1:0]  ctrlWord;
  logic [ADDR_W-1:0] rdAddrQ, wrAddrQ;
  logic [CNT_W-1:0]  countQ;
  logic [DATA_W-1:0] dataQ;

  logic ldCtrl, ldRd, ldWr, ldCnt;
  assign ldCtrl = cfgWrEn && cfgWrAddr[1:0] == 2'd0;
  assign ldRd   = cfgWrEn && cfgWrAddr[1:0] == 2'd1;
  assign ldWr   = cfgWrEn && cfgWrAddr[1:0] == 2'd2;
  assign ldCnt  = cfgWrEn && cfgWrAddr[1:0] == 2'd3;

  assign cfg = cfg_t'(ctrlWord);

  logic rdRing, wrRing;
  assign rdRing = !cfg.ringWr;
  assign wrRing = cfg.ringWr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlWord <= CFG_RESET;
      rdAddrQ  <= '0;
      wrAddrQ  <= '0;
      countQ   <= '0;
      dataQ    <= '0;
    end else begin
      if (ldCtrl) ctrlWord <= cfgWrData[CFG_W-1:0];

      if (ldRd) rdAddrQ <= cfgWrData;
      else if (strobe.advance && cfg.rdInc)
        rdAddrQ <= stepAddr(rdAddrQ, cfg.size, cfg.ringBits, rdRing);

      if (ldWr) wrAddrQ <= cfgWrData;
      else if (strobe.advance && cfg.wrInc)
        wrAddrQ <= stepAddr(wrAddrQ, cfg.size, cfg.ringBits, wrRing);

      if (ldCnt) countQ <= cfgWrData[CNT_W-1:0];
      else if (strobe.advance && countQ != '0) countQ <= countQ - 1'b1;

      if (strobe.takeData) dataQ <= laneSwap(rdData, cfg.size, cfg.swap);
    end
  end

  assign countZero = (countQ == '0);
  assign rdAddr    = rdAddrQ;
  assign wrAddr    = wrAddrQ;
  assign wrData    = dataQ;

  // R5: each completed item lowers the count by exactly one
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.advance && !ldCnt && countQ != '0) |=> countQ == $past(countQ) - 1'b1);

  // R4: a source ring keeps the address bits above the window fixed
  a_r4_ring_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.advance && cfg.rdInc && rdRing && cfg.ringBits != 4'd0 && !ldRd)
      |=> ((rdAddrQ ^ $past(rdAddrQ)) >> $past(cfg.ringBits)) == '0);

endmodule

// File: rtl/dce_ctrl.sv
module dce_ctrl
  import dce_pkg::*;
#(
  parameter int CH_IDX = 2,
  parameter int NREQ   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cfg_t            cfg,
  input  logic            countZero,
  input  logic            cfgWrEn,
  input  logic [2:0]      cfgWrAddr,
  input  logic [31:0]     cfgWrData,
  input  logic            chainIn,
  input  logic            abortReq,
  input  logic            irqClr,
  input  logic [NREQ-1:0] dreq,
  input  logic            rdValid,
  input  logic            wrAck,
  output strobe_t         strobe,
  output logic            rdReq,
  output logic            wrReq,
  output logic            busy,
  output logic            irq,
  output logic            chainFire,
  output logic [3:0]      chainTarget
);

  localparam logic [3:0] SELF = 4'(CH_IDX);

  state_t state, stateNext;
  logic   abortPend;

  logic trigWrite, enAfter, nullWrite, start, paceOk, abortNow, done;

  assign trigWrite = cfgWrEn && cfgWrAddr[2];
  assign enAfter   = (cfgWrAddr[1:0] == 2'd0) ? cfgWrData[0] : cfg.enable;
  assign nullWrite = trigWrite && cfgWrData == 32'd0 && cfg.quiet;
  assign start     = (state == ST_IDLE) &&
                     ((trigWrite && !nullWrite && enAfter) || (chainIn && cfg.enable));
  assign abortNow  = abortReq || abortPend;
  assign done      = (state == ST_ISSUE) && !abortNow && countZero;

  always_comb begin
    paceOk = (cfg.reqSel == REQ_ALWAYS);
    for (int i = 0; i < NREQ; i++) begin
      if (cfg.reqSel == 6'(i)) paceOk = dreq[i];
    end
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:  if (start) stateNext = ST_ISSUE;
      ST_ISSUE: begin
        if (abortNow || countZero)       stateNext = ST_IDLE;
        else if (cfg.enable && paceOk)   stateNext = ST_READ;
      end
      ST_READ:  if (rdValid) stateNext = ST_WRITE;
      ST_WRITE: if (wrAck)   stateNext = ST_ISSUE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      abortPend   <= 1'b0;
      irq         <= 1'b0;
      chainFire   <= 1'b0;
      chainTarget <= SELF;
    end else begin
      state <= stateNext;
      if (stateNext == ST_IDLE)                 abortPend <= 1'b0;
      else if (abortReq && state != ST_IDLE)    abortPend <= 1'b1;

      if ((done && !cfg.quiet) || nullWrite)    irq <= 1'b1;
      else if (irqClr)                          irq <= 1'b0;

      chainFire <= done && cfg.chainTo != SELF;
      if (done) chainTarget <= cfg.chainTo;
    end
  end

  assign strobe.takeData = (state == ST_READ) && rdValid;
  assign strobe.advance  = (state == ST_WRITE) && wrAck;
  assign rdReq = (state == ST_READ);
  assign wrReq = (state == ST_WRITE);
  assign busy  = (state != ST_IDLE);

  // R13: a request is held until its handshake arrives
  a_r13_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && !rdValid) |=> rdReq);
  a_r13_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wrReq && !wrAck) |=> wrReq);

  // R12: data already read is always written, abort or not
  a_r12_abort_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (rdReq && rdValid) |=> wrReq);

  // R11: a new read only starts from an enabled configuration
  a_r11_enabled_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdReq) |-> $past(cfg.enable));

  // R7: the interrupt flag only drops under an explicit clear
  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irqClr) |=> irq);

  // R10: a chain pulse never names this channel
  a_r10_no_self_chain: assert property (@(posedge clk) disable iff (!rst_n)
    chainFire |-> chainTarget != SELF);

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dce_pkg::*;
#(
  parameter int CH_IDX = 2,
  parameter int NREQ   = 4,
  parameter int CNT_W  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfgWrEn,
  input  logic [2:0]      cfgWrAddr,
  input  logic [31:0]     cfgWrData,
  input  logic            irqClr,
  input  logic            chainIn,
  input  logic            abortReq,
  input  logic [NREQ-1:0] dreq,
  output logic            rdReq,
  output logic [31:0]     rdAddr,
  output logic [1:0]      rdSize,
  input  logic            rdValid,
  input  logic [31:0]     rdData,
  output logic            wrReq,
  output logic [31:0]     wrAddr,
  output logic [1:0]      wrSize,
  output logic [31:0]     wrData,
  input  logic            wrAck,
  output logic            busy,
  output logic            irq,
  output logic            chainFire,
  output logic [3:0]      chainTarget
);

  cfg_t    cfg;
  strobe_t strobe;
  logic    countZero;

  dce_datapath #(.CH_IDX(CH_IDX), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgWrEn   (cfgWrEn),
    .cfgWrAddr (cfgWrAddr),
    .cfgWrData (cfgWrData),
    .strobe    (strobe),
    .rdData    (rdData),
    .cfg       (cfg),
    .countZero (countZero),
    .rdAddr    (rdAddr),
    .wrAddr    (wrAddr),
    .wrData    (wrData)
  );

  dce_ctrl #(.CH_IDX(CH_IDX), .NREQ(NREQ)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg         (cfg),
    .countZero   (countZero),
    .cfgWrEn     (cfgWrEn),
    .cfgWrAddr   (cfgWrAddr),
    .cfgWrData   (cfgWrData),
    .chainIn     (chainIn),
    .abortReq    (abortReq),
    .irqClr      (irqClr),
    .dreq        (dreq),
    .rdValid     (rdValid),
    .wrAck       (wrAck),
    .strobe      (strobe),
    .rdReq       (rdReq),
    .wrReq       (wrReq),
    .busy        (busy),
    .irq         (irq),
    .chainFire   (chainFire),
    .chainTarget (chainTarget)
  );

  assign rdSize = cfg.size;
  assign wrSize = cfg.size;

endmodule

// File: tb/sim_dma_chan_engine.sv
module sim_dma_chan_engine;

  localparam int NREQ = 4;
  localparam int SELF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [2:0] cfgWrAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic irqClr = 1'b0, chainIn = 1'b0, abortReq = 1'b0;
  logic [NREQ-1:0] dreq = '0;
  logic rdReq, wrReq, busy, irq, chainFire;
  logic [31:0] rdAddr, wrAddr, wrData;
  logic [1:0] rdSize, wrSize;
  logic rdValid = 1'b0, wrAck = 1'b0;
  logic [31:0] rdData = '0;
  logic [3:0] chainTarget;

  always #5 clk = ~clk;

  dma_chan_engine #(.CH_IDX(SELF), .NREQ(NREQ), .CNT_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .irqClr(irqClr), .chainIn(chainIn),
    .abortReq(abortReq), .dreq(dreq), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdSize(rdSize), .rdValid(rdValid), .rdData(rdData), .wrReq(wrReq),
    .wrAddr(wrAddr), .wrSize(wrSize), .wrData(wrData), .wrAck(wrAck),
    .busy(busy), .irq(irq), .chainFire(chainFire), .chainTarget(chainTarget)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // memory model and logs
  bit holdRd = 0, holdWr = 0;
  logic [31:0] rdLog[0:15];
  logic [31:0] wrALog[0:15];
  logic [31:0] wrDLog[0:15];
  logic [1:0]  wrSLog[0:15];
  int nRd = 0, nWr = 0, chainCnt = 0;
  logic [3:0] lastTarget = '0;

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[7:0] ^ 8'h3C, a[7:0] + 8'd7, ~a[7:0], a[7:0]};
  endfunction

  always @(negedge clk) begin
    rdValid = rdReq && !holdRd;
    rdData  = pat(rdAddr);
    if (rdValid) begin
      if (nRd < 16) rdLog[nRd] = rdAddr;
      nRd++;
    end
    wrAck = wrReq && !holdWr;
    if (wrAck) begin
      if (nWr < 16) begin
        wrALog[nWr] = wrAddr; wrDLog[nWr] = wrData; wrSLog[nWr] = wrSize;
      end
      nWr++;
    end
    if (chainFire) begin
      chainCnt++;
      lastTarget = chainTarget;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = a; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitIdle();
    int guard = 0;
    while (busy && guard < 500) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic pulseClr();
    @(negedge clk); irqClr = 1'b1;
    @(negedge clk); irqClr = 1'b0;
  endtask

  task automatic clearLog();
    nRd = 0; nWr = 0;
  endtask

  function automatic logic [31:0] mkCtrl(input bit en, input int sz, input bit rin, input bit win,
                                         input int ring, input bit rwr, input bit sw, input bit q,
                                         input int req, input int chain);
    return 32'(en) | (32'(sz) << 1) | (32'(rin) << 3) | (32'(win) << 4) | (32'(ring) << 5) |
           (32'(rwr) << 9) | (32'(sw) << 10) | (32'(q) << 11) | (32'(req) << 12) | (32'(chain) << 18);
  endfunction

  function automatic logic [31:0] expStep(input logic [31:0] a, input int sz, input bit inc, input int n);
    logic [31:0] s, m;
    if (!inc) return a;
    s = a + (32'd1 << sz);
    if (n == 0) return s;
    m = (32'd1 << n) - 32'd1;
    return (a & ~m) | (s & m);
  endfunction

  function automatic logic [31:0] expSwap(input logic [31:0] d, input int sz, input bit en);
    if (!en || sz == 0) return d;
    if (sz == 1) return {d[31:16], d[7:0], d[15:8]};
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  // R3 R4 R5 R6 R7 sweep case
  task automatic runCase(input int sz, input bit sw, input int ringMode, input bit rin, input bit win);
    localparam int N = 5;
    int rn, rring, wring;
    bit rwr;
    logic [31:0] ra, wa;
    int chain0;
    rn = (ringMode == 0) ? 0 : (ringMode == 1) ? 3 : 4;
    rwr = (ringMode == 2);
    rring = rwr ? 0 : rn;
    wring = rwr ? rn : 0;
    clearLog();
    chain0 = chainCnt;
    regWrite(3'd1, 32'h0000_2034);
    regWrite(3'd2, 32'h0000_5A0C);
    regWrite(3'd0, mkCtrl(1, sz, rin, win, rn, rwr, sw, 0, 63, SELF));
    regWrite(3'd7, N);
    waitIdle();
    check(nRd == N, "R5 read count", nRd, N);
    check(nWr == N, "R5 write count", nWr, N);
    ra = 32'h0000_2034; wa = 32'h0000_5A0C;
    for (int i = 0; i < N; i++) begin
      check(rdLog[i] == ra, "R3/R4 read address", rdLog[i], ra);
      check(wrALog[i] == wa, "R3/R4 write address", wrALog[i], wa);
      check(wrDLog[i] == expSwap(pat(ra), sz, sw), "R6 write data", wrDLog[i], expSwap(pat(ra), sz, sw));
      check(wrSLog[i] == 2'(sz), "R3 size code", 32'(wrSLog[i]), sz);
      ra = expStep(ra, sz, rin, rring);
      wa = expStep(wa, sz, win, wring);
    end
    check(irq == 1'b1, "R7 completion irq", irq, 1);
    check(chainCnt == chain0, "R10 self chain silent", chainCnt, chain0);
    pulseClr();
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int c0;
    waitCycles(3);
    // R1 reset state
    check(busy == 0, "R1 busy", busy, 0);
    check(irq == 0, "R1 irq", irq, 0);
    check(rdReq == 0 && wrReq == 0, "R1 requests", {rdReq, wrReq}, 0);
    check(chainFire == 0, "R1 chainFire", chainFire, 0);
    rst_n = 1'b1;
    waitCycles(2);
    check(busy == 0 && irq == 0, "R1 after release", {busy, irq}, 0);

    // R3 R4 R6 near-exhaustive sweep
    for (int sz = 0; sz < 3; sz++)
      for (int sw = 0; sw < 2; sw++)
        for (int rm = 0; rm < 3; rm++)
          for (int inc = 0; inc < 4; inc++)
            runCase(sz, sw[0], rm, inc[0], inc[1]);

    // R2 plain alias only loads
    clearLog();
    regWrite(3'd0, mkCtrl(1, 2, 1, 1, 0, 0, 0, 0, 63, SELF));
    regWrite(3'd3, 2);
    waitCycles(3);
    check(busy == 0, "R2 plain write no start", busy, 0);
    check(nRd == 0, "R2 plain write no reads", nRd, 0);
    regWrite(3'd6, 32'h0000_0100);
    waitIdle();
    check(nWr == 2, "R2 trigger alias starts", nWr, 2);
    check(wrALog[0] == 32'h100, "R2 trigger alias loads", wrALog[0], 32'h100);
    pulseClr();

    // R5 zero count start
    clearLog();
    regWrite(3'd7, 0);
    waitIdle();
    check(nRd == 0, "R5 zero count no transfer", nRd, 0);
    check(irq == 1, "R5 zero count completes", irq, 1);
    pulseClr();
    check(irq == 0, "R7 irq cleared", irq, 0);

    // R7 set wins over clear in the same cycle
    regWrite(3'd3, 1);
    regWrite(3'd0, mkCtrl(1, 2, 1, 1, 0, 0, 0, 0, 63, SELF) | 32'h0);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = 3'd4; cfgWrData = mkCtrl(1, 2, 1, 1, 0, 0, 0, 0, 63, SELF);
    @(negedge clk);
    cfgWrEn = 1'b0; irqClr = 1'b1;
    waitIdle();
    check(irq == 1, "R7 set beats clear", irq, 1);
    irqClr = 1'b0;
    @(negedge clk);
    check(irq == 1, "R7 irq stays sticky", irq, 1);
    pulseClr();

    // R8 quiet mode
    clearLog();
    regWrite(3'd0, mkCtrl(1, 2, 1, 1, 0, 0, 0, 1, 63, SELF));
    regWrite(3'd7, 2);
    waitIdle();
    check(nWr == 2 && irq == 0, "R8 quiet no end irq", {nWr[30:0], irq}, 32'd4);
    regWrite(3'd5, 0);
    check(irq == 1, "R8 null trigger irq", irq, 1);
    check(busy == 0, "R8 null trigger no start", busy, 0);
    pulseClr();

    // R9 pacing by request line
    clearLog();
    dreq = '0;
    regWrite(3'd0, mkCtrl(1, 2, 1, 1, 0, 0, 0, 0, 1, SELF));
    regWrite(3'd7, 2);
    waitCycles(6);
    check(busy == 1 && nRd == 0, "R9 waits for request", {busy, nRd[30:0]}, 32'h1 << 31);
    dreq = 4'b0010;
    waitIdle();
    check(nWr == 2, "R9 proceeds on request", nWr, 2);
    pulseClr();
    clearLog();
    dreq = 4'hF;
    regWrite(3'd0, mkCtrl(1, 2, 1, 1, 0, 0, 0, 0, 5, SELF));
    regWrite(3'd7, 1);
    waitCycles(6);
    check(busy == 1 && nRd == 0, "R9 out-of-range never paces", {busy, nRd[30:0]}, 32'h1 << 31);
    @(negedge clk); abortReq = 1'b1;
    @(negedge clk); abortReq = 1'b0;
    waitIdle();
    check(busy == 0 && irq == 0, "R12 abort while waiting", {busy, irq}, 0);
    dreq = '0;

    // R11 pause by clearing enable
    clearLog();
    regWrite(3'd0, mkCtrl(1, 2, 1, 1, 0, 0, 0, 0, 0, SELF));
    regWrite(3'd7, 3);
    waitCycles(2);
    regWrite(3'd0, mkCtrl(0, 2, 1, 1, 0, 0, 0, 0, 63, SELF));
    waitCycles(5);
    check(busy == 1, "R11 busy held while paused", busy, 1);
    check(nRd == 0, "R11 no reads while paused", nRd, 0);
    regWrite(3'd0, mkCtrl(1, 2, 1, 1, 0, 0, 0, 0, 63, SELF));
    waitIdle();
    check(nWr == 3, "R11 resumes", nWr, 3);
    pulseClr();
    clearLog();
    regWrite(3'd0, mkCtrl(0, 2, 1, 1, 0, 0, 0, 0, 63, SELF));
    regWrite(3'd7, 2);
    waitCycles(3);
    check(busy == 0 && nRd == 0, "R11 trigger ignored when disabled", busy, 0);
    @(negedge clk); chainIn = 1'b1;
    @(negedge clk); chainIn = 1'b0;
    waitCycles(2);
    check(busy == 0, "R11 chainIn ignored when disabled", busy, 0);

    // R10 chaining
    clearLog();
    c0 = chainCnt;
    regWrite(3'd0, mkCtrl(1, 2, 1, 1, 0, 0, 0, 0, 63, 5));
    regWrite(3'd7, 1);
    waitIdle();
    @(negedge clk);
    check(chainCnt == c0 + 1, "R10 chain pulse count", chainCnt, c0 + 1);
    check(lastTarget == 4'd5, "R10 chain target", lastTarget, 5);
    regWrite(3'd3, 2);
    clearLog();
    @(negedge clk); chainIn = 1'b1;
    @(negedge clk); chainIn = 1'b0;
    waitIdle();
    @(negedge clk);
    check(nWr == 2, "R10 chainIn starts channel", nWr, 2);
    check(chainCnt == c0 + 2, "R10 second chain pulse", chainCnt, c0 + 2);
    pulseClr();

    // R12 abort with an outstanding read
    clearLog();
    c0 = chainCnt;
    holdRd = 1;
    regWrite(3'd7, 4);
    while (!rdReq) @(negedge clk);
    abortReq = 1'b1;
    @(negedge clk); abortReq = 1'b0;
    waitCycles(3);
    check(busy == 1, "R12 busy until drained", busy, 1);
    holdRd = 0;
    waitIdle();
    @(negedge clk);
    check(nRd == 1 && nWr == 1, "R12 in-flight item written", {nRd[15:0], nWr[15:0]}, 32'h0001_0001);
    check(irq == 0, "R12 no irq on abort", irq, 0);
    check(chainCnt == c0, "R12 no chain on abort", chainCnt, c0);

    // R13 write handshake held
    clearLog();
    holdWr = 1;
    regWrite(3'd7, 1);
    while (!wrReq) @(negedge clk);
    waitCycles(3);
    check(wrReq == 1 && rdReq == 0, "R13 write held, one in flight", {wrReq, rdReq}, 2);
    check(nWr == 0, "R13 no write before ack", nWr, 0);
    holdWr = 0;
    waitIdle();
    check(nWr == 1, "R13 write completes", nWr, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule